// File: doc/BRIEF.md
# Serial Line Transmitter with Break and Idle Generation

This block drives one asynchronous serial output line. It sends data frames of eight or nine bits, idle characters (the line held high for one frame time) and break characters (the line held low for one frame time). A divisor counter inside the block sets the bit period. A small control word holds the transmit-enable, word-length and break bits. A one-entry holding register takes the next word while the current frame is being shifted out.

All frame timing advances only on the divisor tick. Requests for idle, break and data are examined only at a frame boundary, meaning a tick on which no frame is running or the last slot of the current frame ends. This keeps every break exactly one frame long, whatever the phase of the request against the tick. It also makes the number of breaks follow the control writes exactly. When several requests wait at the same boundary, an idle goes first, then a break, then data.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `dat_ready` is 1. The control word resets to all zeros, so the transmitter is disabled.
- R2: Every bit slot lasts exactly `div` clock cycles, where `div` is the last value written on the divisor port, and a written 0 acts as 1. `txd` changes only on a divisor tick.
- R3: A data frame is one low start bit, then the data bits LSB first, then one high stop bit. There are 8 data bits when control bit 1 is 0 and 9 data bits when it is 1. Control bit 0 is the transmit enable and control bit 2 is the break bit.
- R4: `dat_ready` is 1 while the holding register is empty. A write with `dat_ready` high is accepted and drops `dat_ready`. A write with `dat_ready` low is ignored. When the holding register is refilled in time, data frames follow each other with no gap.
- R5: A break holds `txd` low for exactly 10 bit times with 8-bit words, or 11 bit times with 9-bit words, followed by one high bit time. It is never longer, whatever the request phase.
- R6: Writing the break bit to 1 and then back to 0 produces exactly one break, which starts at the next frame boundary.
- R7: While the break bit stays 1, breaks are sent back to back, one per frame boundary. A break that has started always runs to its end, even if the bit is cleared partway through.
- R8: A write that changes the enable bit from 0 to 1 queues one idle frame. The idle frame keeps `txd` high and `busy` high for one frame time, ahead of any other frame.
- R9: At a frame boundary a pending idle is served first, then a pending break, then a held data word.
- R10: With the enable bit at 0, no new frame starts, a frame already in progress completes, and held data stays pending.
- R11: `busy` is 1 exactly while an idle, break or data frame is in progress. It is 0 with the line high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control word: bit0 enable, bit1 nine-bit words, bit2 break |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Bit period in clock cycles |
| dat_we | input | 1 | Data write strobe |
| dat_wdata | input | 9 | Data word; bit 8 is used only in nine-bit mode |
| dat_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial output line, high when idle |
| busy | output | 1 | A frame is in progress |

## Verification
The critical collision is a control write that raises or drops the break bit in the same clock cycle as the tick that closes a frame. This decides whether the break is taken at that boundary or at the next one. The bench provokes it by sweeping the delay between a divisor write and a break pulse over every offset across two bit periods, for divisors 1 to 5 and both word lengths. Every case must yield exactly one break that is all-low for the full frame, followed by a high stop slot. A second collision, where idle, break and held data all wait at one boundary, is judged by the measured start times and the order of the decoded frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int unsigned WORD_MAX = 9;
    localparam int unsigned SLOT_W   = 4;

    typedef enum logic [1:0] {
        FR_NONE,
        FR_IDLE,
        FR_BRK,
        FR_DATA
    } frame_e;

    typedef struct packed {
        logic brk;
        logic nine;
        logic on;
    } ctl_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned DIV_RESET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             tick,
    output logic [DIV_W-1:0] div_val
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } baud_t;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    baud_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (div_we) begin
            st_d.div = (div_wdata == '0) ? ONE : div_wdata;
            st_d.cnt = st_d.div - ONE;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = st_q.div - ONE;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.div <= DIV_W'(DIV_RESET);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick    = (st_q.cnt == '0);
    assign div_val = st_q.div;
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [2:0]          ctl_wdata,
    input  logic                dat_we,
    input  logic [WORD_MAX-1:0] dat_wdata,
    input  logic                take_idle,
    input  logic                take_brk,
    input  logic                take_data,
    output logic                on,
    output logic                nine,
    output logic                idle_req,
    output logic                brk_req,
    output logic                hold_full,
    output logic [WORD_MAX-1:0] hold_data
);
    typedef struct packed {
        ctl_t                ctl;
        logic                idle_pend;
        logic                brk_latch;
        logic                full;
        logic [WORD_MAX-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;
    ctl_t  wr_ctl;

    always_comb begin
        r_d    = r_q;
        wr_ctl = ctl_t'(ctl_wdata);
        // consumption by the sequencer at a frame boundary
        if (take_idle) r_d.idle_pend = 1'b0;
        if (take_brk)  r_d.brk_latch = 1'b0;
        if (take_data) r_d.full      = 1'b0;
        // a new control write is applied after consumption
        if (ctl_we) begin
            if (wr_ctl.on && !r_q.ctl.on)   r_d.idle_pend = 1'b1;
            if (wr_ctl.brk && !r_q.ctl.brk) r_d.brk_latch = 1'b1;
            r_d.ctl = wr_ctl;
        end
        if (dat_we && !r_q.full) begin
            r_d.hold = dat_wdata;
            r_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign on        = r_q.ctl.on;
    assign nine      = r_q.ctl.nine;
    assign idle_req  = r_q.idle_pend;
    assign brk_req   = r_q.brk_latch | r_q.ctl.brk;
    assign hold_full = r_q.full;
    assign hold_data = r_q.hold;
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                on,
    input  logic                nine,
    input  logic                idle_req,
    input  logic                brk_req,
    input  logic                hold_full,
    input  logic [WORD_MAX-1:0] hold_data,
    output logic                take_idle,
    output logic                take_brk,
    output logic                take_data,
    output logic                txd,
    output logic                busy
);
    typedef struct packed {
        frame_e              kind;
        logic                nine;
        logic [SLOT_W-1:0]   slot;
        logic [WORD_MAX-1:0] shf;
        logic                txd;
    } seq_t;

    seq_t s_d, s_q;

    logic [SLOT_W-1:0] wbits;
    logic [SLOT_W-1:0] flen;
    logic [SLOT_W-1:0] last;
    logic [SLOT_W-1:0] nslot;
    logic              boundary;

    always_comb begin
        s_d       = s_q;
        take_idle = 1'b0;
        take_brk  = 1'b0;
        take_data = 1'b0;
        wbits     = s_q.nine ? SLOT_W'(WORD_MAX) : SLOT_W'(WORD_MAX - 1);
        flen      = wbits + SLOT_W'(2);
        // a break owns one extra slot: its trailing high stop bit
        last      = (s_q.kind == FR_BRK) ? flen : flen - SLOT_W'(1);
        nslot     = s_q.slot + SLOT_W'(1);
        boundary  = tick && ((s_q.kind == FR_NONE) || (s_q.slot == last));

        if (boundary) begin
            s_d.slot = '0;
            s_d.nine = nine;
            if (on && idle_req) begin
                s_d.kind  = FR_IDLE;
                s_d.txd   = 1'b1;
                take_idle = 1'b1;
            end else if (on && brk_req) begin
                s_d.kind  = FR_BRK;
                s_d.txd   = 1'b0;
                take_brk  = 1'b1;
            end else if (on && hold_full) begin
                s_d.kind  = FR_DATA;
                s_d.txd   = 1'b0;
                s_d.shf   = hold_data;
                take_data = 1'b1;
            end else begin
                s_d.kind  = FR_NONE;
                s_d.txd   = 1'b1;
            end
        end else if (tick) begin
            s_d.slot = nslot;
            unique case (s_q.kind)
                FR_DATA: begin
                    if (nslot <= wbits) begin
                        s_d.txd = s_q.shf[0];
                        s_d.shf = s_q.shf >> 1;
                    end else begin
                        s_d.txd = 1'b1;
                    end
                end
                FR_BRK:  s_d.txd = (nslot == flen);
                default: s_d.txd = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.kind <= FR_NONE;
            s_q.nine <= 1'b0;
            s_q.slot <= '0;
            s_q.shf  <= '0;
            s_q.txd  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.txd;
    assign busy = (s_q.kind != FR_NONE);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned DIV_RESET = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             dat_we,
    input  logic [8:0]       dat_wdata,
    output logic             dat_ready,
    output logic             txd,
    output logic             busy
);
    logic                tick_w;
    logic [DIV_W-1:0]    div_w;
    logic                on_w, nine_w, idle_w, brk_w, full_w;
    logic [WORD_MAX-1:0] hold_w;
    logic                tk_idle, tk_brk, tk_data;

    sertx_baud #(
        .DIV_W    (DIV_W),
        .DIV_RESET(DIV_RESET)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_we   (div_we),
        .div_wdata(div_wdata),
        .tick     (tick_w),
        .div_val  (div_w)
    );

    sertx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_wdata(ctl_wdata),
        .dat_we   (dat_we),
        .dat_wdata(dat_wdata),
        .take_idle(tk_idle),
        .take_brk (tk_brk),
        .take_data(tk_data),
        .on       (on_w),
        .nine     (nine_w),
        .idle_req (idle_w),
        .brk_req  (brk_w),
        .hold_full(full_w),
        .hold_data(hold_w)
    );

    sertx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .on       (on_w),
        .nine     (nine_w),
        .idle_req (idle_w),
        .brk_req  (brk_w),
        .hold_full(full_w),
        .hold_data(hold_w),
        .take_idle(tk_idle),
        .take_brk (tk_brk),
        .take_data(tk_data),
        .txd      (txd),
        .busy     (busy)
    );

    assign dat_ready = !full_w;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             busy,
    input logic             dat_we,
    input logic             dat_ready,
    input logic             tick,
    input logic [DIV_W-1:0] div_val
);
    localparam int unsigned RUN_W = DIV_W + 5;

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= txd ? '0 : run_q + RUN_W'(1);
        end
    end

    assign run_lim = RUN_W'(div_val) * RUN_W'(11);

    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick));

    // R5
    break_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= run_lim);

    // R4
    hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && dat_ready) |=> !dat_ready);

    // R11
    busy_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick));
endmodule

bind sertx_top sertx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .busy     (busy),
    .dat_we   (dat_we),
    .dat_ready(dat_ready),
    .tick     (tick_w),
    .div_val  (div_w)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [2:0]       ctl_wdata = '0;
    logic             div_we = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             dat_we = 1'b0;
    logic [8:0]       dat_wdata = '0;
    logic             dat_ready, txd, busy;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int D = 16;
    logic cfg_nine = 1'b0;
    int t_last = 0;
    bit done = 0;

    int q_kind[$];
    int q_data[$];
    int q_t0[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sertx_top #(.DIV_W(DIV_W), .DIV_RESET(16)) i_sertx_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .dat_we(dat_we),
        .dat_wdata(dat_wdata), .dat_ready(dat_ready), .txd(txd), .busy(busy)
    );

    // line monitor: kind 0 data, 1 break, 2 malformed
    initial begin
        forever begin
            int t0, nb, val;
            logic [11:0] mid;
            logic all_low;
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                t0 = cyc;
                nb = cfg_nine ? 9 : 8;
                mid = '0;
                all_low = 1'b1;
                for (int s = 0; s < nb + 2; s++) begin
                    for (int k = 0; k < D; k++) begin
                        if (!(s == 0 && k == 0)) @(negedge clk);
                        if (k == D / 2) mid[s] = txd;
                        if (txd !== 1'b0) all_low = 1'b0;
                    end
                end
                if (all_low) begin
                    @(negedge clk);
                    q_kind.push_back((txd === 1'b1) ? 1 : 2);
                    q_data.push_back(0);
                end else begin
                    val = 0;
                    for (int i = 0; i < nb; i++) if (mid[i+1]) val += (1 << i);
                    q_kind.push_back((mid[0] == 1'b0 && mid[nb+1] == 1'b1) ? 0 : 2);
                    q_data.push_back(val);
                end
                q_t0.push_back(t0);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic clr_q();
        q_kind.delete(); q_data.delete(); q_t0.delete();
    endtask

    task automatic wr_ctl(input logic on, input logic nine, input logic brk);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {brk, nine, on}; cfg_nine = nine; t_last = cyc;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_brk(input logic nine);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {1'b1, nine, 1'b1}; t_last = cyc;
        @(negedge clk);
        ctl_wdata = {1'b0, nine, 1'b1};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_div(input int d);
        @(negedge clk);
        div_we = 1'b1; div_wdata = DIV_W'(d); D = d;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic send(input int v);
        do @(negedge clk); while (dat_ready !== 1'b1);
        dat_we = 1'b1; dat_wdata = 9'(v);
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic wait_quiet();
        int qc = 0;
        while (qc < 12 * D + 4) begin
            @(negedge clk);
            if (busy) qc = 0; else qc++;
        end
    endtask

    initial begin
        int ten, flen, P;
        int vals8[6];
        int vals9[6];
        vals8 = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        vals9 = '{9'h000, 9'h1FF, 9'h155, 9'h0AA, 9'h100, 9'h001};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 dat_ready", int'(dat_ready), 1);
        wait_quiet();
        chk("R10 no frame while disabled", q_kind.size(), 0);

        // R3 R4 R8 R2: eight-bit frames after idle preamble, back to back
        wr_div(4);
        clr_q();
        wr_ctl(1'b1, 1'b0, 1'b0);
        ten = t_last;
        foreach (vals8[i]) send(vals8[i]);
        wait_quiet();
        chk("R3 frame count", q_kind.size(), 6);
        foreach (vals8[i]) begin
            chk("R3 kind", q_kind[i], 0);
            chk("R3 data", q_data[i], vals8[i]);
            if (i > 0) chk("R4 R2 back-to-back spacing", q_t0[i] - q_t0[i-1], 40);
        end
        chk_rng("R8 idle ahead of first frame", q_t0[0] - ten, 40, 40 + 4 + 3);

        // R3 exhaustive eight-bit sweep at div 2
        wr_div(2);
        clr_q();
        for (int v = 0; v < 256; v++) send(v);
        wait_quiet();
        chk("R3 sweep8 count", q_kind.size(), 256);
        for (int v = 0; v < 256; v++) begin
            chk("R3 sweep8 data", q_data[v], v);
            chk("R3 sweep8 kind", q_kind[v], 0);
        end

        // R3 nine-bit words
        wr_ctl(1'b0, 1'b1, 1'b0);
        wr_div(3);
        wr_ctl(1'b1, 1'b1, 1'b0);
        wait_quiet();
        clr_q();
        foreach (vals9[i]) send(vals9[i]);
        wait_quiet();
        chk("R3 nine count", q_kind.size(), 6);
        foreach (vals9[i]) begin
            chk("R3 nine data", q_data[i], vals9[i]);
            if (i > 0) chk("R2 nine spacing", q_t0[i] - q_t0[i-1], 33);
        end

        // R3 exhaustive nine-bit sweep at div 1 (0 written acts as 1)
        wr_div(0);
        D = 1;
        clr_q();
        for (int v = 0; v < 512; v++) send(v);
        wait_quiet();
        chk("R3 sweep9 count", q_kind.size(), 512);
        for (int v = 0; v < 512; v++) chk("R3 sweep9 data", q_data[v], v);
        chk("R2 div zero spacing", q_t0[1] - q_t0[0], 11);

        // R5 R6 break phase sweep
        for (int nn = 0; nn < 2; nn++) begin
            wr_ctl(1'b0, nn[0], 1'b0);
            wr_ctl(1'b1, nn[0], 1'b0);
            for (int d = 1; d <= 5; d++) begin
                for (int off = 0; off <= 2 * d; off++) begin
                    wr_div(d);
                    wait_quiet();
                    clr_q();
                    wr_div(d);
                    repeat (off) @(negedge clk);
                    pulse_brk(nn[0]);
                    ten = t_last;
                    wait_quiet();
                    chk("R6 one break per pulse", q_kind.size(), 1);
                    chk("R5 break shape", q_kind[0], 1);
                    chk_rng("R6 break start", q_t0[0] - ten, 0, d + 3);
                end
            end
        end

        // R7 held break: back to back, last one completes after clear
        wr_ctl(1'b0, 1'b0, 1'b0);
        wr_div(3);
        wr_ctl(1'b1, 1'b0, 1'b0);
        wait_quiet();
        clr_q();
        P = 11 * 3;
        wr_ctl(1'b1, 1'b0, 1'b1);
        do @(negedge clk); while (!busy);
        repeat (2 * P + P / 2) @(negedge clk);
        wr_ctl(1'b1, 1'b0, 1'b0);
        wait_quiet();
        chk("R7 held break count", q_kind.size(), 3);
        for (int i = 0; i < 3; i++) chk("R7 held break shape", q_kind[i], 1);
        chk("R7 break spacing", q_t0[1] - q_t0[0], P);
        chk("R7 break spacing 2", q_t0[2] - q_t0[1], P);

        // R9 R8 R11 priority: idle, then break, then held data
        wr_ctl(1'b0, 1'b0, 1'b0);
        wr_div(2);
        wait_quiet();
        clr_q();
        send(9'h03C);
        chk("R4 ready low after write", int'(dat_ready), 0);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 3'b101; ten = cyc;
        @(negedge clk);
        ctl_wdata = 3'b001;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 busy during idle", int'(busy), 1);
        chk("R8 line high during idle", int'(txd), 1);
        wait_quiet();
        chk("R9 frame count", q_kind.size(), 2);
        chk("R9 break first", q_kind[0], 1);
        chk("R9 data second", q_kind[1], 0);
        chk("R9 data value", q_data[1], 9'h03C);
        flen = 10 * 2;
        chk_rng("R8 R9 idle before break", q_t0[0] - ten, flen, flen + 2 + 3);
        chk("R5 stop slot after break", q_t0[1] - q_t0[0], 11 * 2);

        // R9 break requested during a data frame waits for its end
        clr_q();
        send(9'h055);
        do @(negedge clk); while (!busy);
        repeat (5) @(negedge clk);
        pulse_brk(1'b0);
        wait_quiet();
        chk("R9 data then break count", q_kind.size(), 2);
        chk("R9 data intact", q_data[0], 9'h055);
        chk("R7 break after data", q_kind[1], 1);
        chk("R7 break follows frame", q_t0[1] - q_t0[0], 20);

        // R10 R4 disable mid-frame, ignored write, resume
        wr_div(3);
        wait_quiet();
        clr_q();
        send(9'h011);
        send(9'h022);
        wr_ctl(1'b0, 1'b0, 1'b0);
        wait_quiet();
        chk("R10 current frame completes", q_kind.size(), 1);
        chk("R10 completed data", q_data[0], 9'h011);
        chk("R10 held word stays", int'(dat_ready), 0);
        chk("R11 busy low when disabled", int'(busy), 0);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = 9'h033;
        @(negedge clk);
        dat_we = 1'b0;
        wr_ctl(1'b1, 1'b0, 1'b0);
        ten = t_last;
        wait_quiet();
        chk("R4 ignored write count", q_kind.size(), 2);
        chk("R4 held word sent, not overwritten", q_data[1], 9'h022);
        chk_rng("R8 idle on re-enable", q_t0[1] - ten, 30, 30 + 3 + 3);
        chk("R11 final busy", int'(busy), 0);
        chk("R11 final txd", int'(txd), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule